// File: doc/BRIEF.md
# Dual-Mode Quad-Channel Host Bus Front End

This block sits between a host processor and a four-channel serial peripheral. All four channels share one 8-bit data bus and a 3-bit register offset. A static style pin selects one of two host bus conventions. In strobe style there are four per-channel active-low selects and separate active-low read and write strobes. In select-plus-direction style there is one active-low select and a read/write direction line, and two upper address bits name the channel.

The block turns either convention into per-channel register read and write enables with a shared offset and write data. It steers the addressed channel's read data onto the shared bus and drives the bus output enable. It presents the channel interrupts in the format the style calls for, and it decodes the reset pin with the polarity that belongs to the style. Reads are combinational and need no clock. A write is committed one clock after its strobe or select is released. Each channel's register file is a plain eight-entry stub.

Top module: `hbus_quad_front`

## Requirements
- R1: In strobe style (style pin = 1), a low select sel_n[i] together with rd_n low and wr_n high is a read of channel i. reg_rd_en is one-hot at bit i, reg_off equals addr[2:0], and data_out carries that channel's register at that offset.
- R2: In strobe style, a low select with wr_n low and rd_n high is a write. On the first cycle after wr_n or the select goes high, reg_wr_en pulses for exactly one cycle at bit i, and the next clock edge stores the data held during the strobe.
- R3: In strobe style, if more than one select is low during a strobe, the lowest-numbered channel is accessed and multi_sel is high.
- R4: In select-plus-direction style (style pin = 0), addr[4:3] = 0, 1, 2, 3 addresses channels 0, 1, 2, 3.
- R5: In select-plus-direction style, sel_n[0] low with rw_n high is a read and with rw_n low is a write. The write enable does not pulse while the select is low. It pulses on the first cycle after sel_n[0] rises.
- R6: data_oe is high only during a valid read. Otherwise it is low and data_out is zero.
- R7: In strobe style, int_out[i] equals chan_irq[i] for every channel (active high).
- R8: In select-plus-direction style, int_out[0] is low when any chan_irq bit is high and high otherwise, and int_out[3:1] are held low.
- R9: The reset pin is active high in strobe style and active low in select-plus-direction style. Reset clears every channel register to zero.
- R10: Strobe style ignores addr[4:3] and rw_n. Select-plus-direction style ignores sel_n[3:1], rd_n and wr_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for write capture and the register stubs |
| style_strobe | input | 1 | Static bus style: 1 = per-channel selects with strobes, 0 = single select with direction |
| rst_pin | input | 1 | Reset pin; polarity set by style |
| sel_n | input | 4 | Active-low selects (only bit 0 used in single-select style) |
| rd_n | input | 1 | Active-low read strobe (strobe style) |
| wr_n | input | 1 | Active-low write strobe (strobe style) |
| rw_n | input | 1 | Direction, high = read (single-select style) |
| addr | input | 5 | [2:0] register offset, [4:3] channel in single-select style |
| data_in | input | 8 | Host write data |
| data_out | output | 8 | Read data toward the host |
| data_oe | output | 1 | Output enable for the shared data bus |
| chan_irq | input | 4 | Per-channel interrupt requests, active high |
| int_out | output | 4 | Interrupt pins in style format |
| reg_rd_en | output | 4 | Per-channel register read enable |
| reg_wr_en | output | 4 | Per-channel register write pulse |
| reg_off | output | 3 | Register offset of the current read or committing write |
| reg_wdata | output | 8 | Data of the committing write |
| multi_sel | output | 1 | More than one select low during a strobe |

## Verification
A wrong channel choice in the decoder shows at once on reg_rd_en and data_out during the same read, before any clock edge. A fault in the write snapshot registers only shows one cycle after the strobe is released, as a missing, doubled or misrouted reg_wr_en pulse. It then shows as wrong data on a later read of that channel. A wrong reset polarity shows as registers that were not cleared, or that are wiped on every cycle.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int AW  = 3;
    localparam int CHW = $clog2(NCH);
    localparam int NREG = 1 << AW;

    typedef enum logic {
        STYLE_SELDIR = 1'b0,
        STYLE_STROBE = 1'b1
    } bus_style_e;

    typedef struct packed {
        logic           rd;
        logic           wr;
        logic           multi;
        logic [CHW-1:0] chan;
    } access_t;

    function automatic logic [CHW-1:0] first_low(input logic [NCH-1:0] sel_n);
        logic [CHW-1:0] idx;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (!sel_n[i]) idx = CHW'(i);
        end
        return idx;
    endfunction

    function automatic int unsigned low_count(input logic [NCH-1:0] sel_n);
        int unsigned n;
        n = 0;
        for (int i = 0; i < NCH; i++) begin
            if (!sel_n[i]) n++;
        end
        return n;
    endfunction
endpackage

// File: rtl/hbus_decode.sv
module hbus_decode
    import hbus_pkg::*;
#(
    parameter int NC  = NCH,
    parameter int CW  = CHW
) (
    input  bus_style_e      style,
    input  logic [NC-1:0]   sel_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic            rw_n,
    input  logic [CW-1:0]   chan_addr,
    output access_t         acc
);
    logic any_sel;
    logic strobe_any;

    always_comb begin
        acc        = '0;
        any_sel    = ~&sel_n;
        strobe_any = ~rd_n | ~wr_n;
        if (style == STYLE_STROBE) begin
            acc.chan  = first_low(sel_n);
            acc.rd    = any_sel & ~rd_n & wr_n;
            acc.wr    = any_sel & ~wr_n & rd_n;
            acc.multi = strobe_any & (low_count(sel_n) > 1);
        end else begin
            acc.chan  = chan_addr;
            acc.rd    = ~sel_n[0] & rw_n;
            acc.wr    = ~sel_n[0] & ~rw_n;
            acc.multi = 1'b0;
        end
    end
endmodule

// File: rtl/hbus_wrcap.sv
module hbus_wrcap
    import hbus_pkg::*;
#(
    parameter int NC = NCH,
    parameter int W  = DW,
    parameter int A  = AW
) (
    input  logic          clk,
    input  logic          rst,
    input  access_t       acc,
    input  logic [A-1:0]  off_in,
    input  logic [W-1:0]  data_in,
    output logic [NC-1:0] wr_en,
    output logic [A-1:0]  wr_off,
    output logic [W-1:0]  wr_data
);
    logic           act_q;
    logic [CHW-1:0] chan_q;
    logic           commit;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            chan_q  <= '0;
            wr_off  <= '0;
            wr_data <= '0;
        end else begin
            act_q <= acc.wr;
            if (acc.wr) begin
                chan_q  <= acc.chan;
                wr_off  <= off_in;
                wr_data <= data_in;
            end
        end
    end

    assign commit = act_q & ~acc.wr;

    always_comb begin
        wr_en = '0;
        for (int i = 0; i < NC; i++) begin
            wr_en[i] = commit & (chan_q == CHW'(i));
        end
    end

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (|wr_en) |=> (wr_en == '0));
    a_r2_onehot_write: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));
    a_r5_no_pulse_while_held: assert property (@(posedge clk) disable iff (rst)
        acc.wr |-> (wr_en == '0));
endmodule

// File: rtl/hbus_regstub.sv
module hbus_regstub #(
    parameter int W = 8,
    parameter int A = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [A-1:0] waddr,
    input  logic [W-1:0] wdata,
    input  logic [A-1:0] raddr,
    output logic [W-1:0] rdata
);
    localparam int DEPTH = 1 << A;
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/hbus_quad_front.sv
module hbus_quad_front
    import hbus_pkg::*;
(
    input  logic            clk,
    input  logic            style_strobe,
    input  logic            rst_pin,
    input  logic [NCH-1:0]  sel_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic            rw_n,
    input  logic [AW+CHW-1:0] addr,
    input  logic [DW-1:0]   data_in,
    output logic [DW-1:0]   data_out,
    output logic            data_oe,
    input  logic [NCH-1:0]  chan_irq,
    output logic [NCH-1:0]  int_out,
    output logic [NCH-1:0]  reg_rd_en,
    output logic [NCH-1:0]  reg_wr_en,
    output logic [AW-1:0]   reg_off,
    output logic [DW-1:0]   reg_wdata,
    output logic            multi_sel
);
    bus_style_e     style;
    logic           core_rst;
    access_t        acc;
    logic [AW-1:0]  wr_off;
    logic [DW-1:0]  rdata [NCH];

    assign style    = bus_style_e'(style_strobe);
    assign core_rst = (style == STYLE_STROBE) ? rst_pin : ~rst_pin;

    hbus_decode #(.NC(NCH), .CW(CHW)) u_dec (
        .style     (style),
        .sel_n     (sel_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .rw_n      (rw_n),
        .chan_addr (addr[AW+CHW-1:AW]),
        .acc       (acc)
    );

    hbus_wrcap #(.NC(NCH), .W(DW), .A(AW)) u_wr (
        .clk     (clk),
        .rst     (core_rst),
        .acc     (acc),
        .off_in  (addr[AW-1:0]),
        .data_in (data_in),
        .wr_en   (reg_wr_en),
        .wr_off  (wr_off),
        .wr_data (reg_wdata)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign reg_rd_en[g] = acc.rd & (acc.chan == CHW'(g));
        hbus_regstub #(.W(DW), .A(AW)) u_stub (
            .clk   (clk),
            .rst   (core_rst),
            .we    (reg_wr_en[g]),
            .waddr (wr_off),
            .wdata (reg_wdata),
            .raddr (addr[AW-1:0]),
            .rdata (rdata[g])
        );
    end

    assign reg_off   = (|reg_wr_en) ? wr_off : addr[AW-1:0];
    assign data_oe   = acc.rd;
    assign data_out  = acc.rd ? rdata[acc.chan] : '0;
    assign multi_sel = acc.multi;

    always_comb begin
        if (style == STYLE_STROBE) begin
            int_out = chan_irq;
        end else begin
            int_out    = '0;
            int_out[0] = ~|chan_irq;
        end
    end

    a_r6_oe_needs_enable: assert property (@(posedge clk) disable iff (core_rst)
        data_oe |-> $onehot(reg_rd_en));
    a_r6_idle_bus_zero: assert property (@(posedge clk) disable iff (core_rst)
        !data_oe |-> (data_out == '0 && reg_rd_en == '0));
    a_r8_unused_irq_low: assert property (@(posedge clk) disable iff (core_rst)
        (style == STYLE_SELDIR) |-> (int_out[NCH-1:1] == '0));
    a_r3_multi_only_strobe: assert property (@(posedge clk) disable iff (core_rst)
        multi_sel |-> (style == STYLE_STROBE && low_count(sel_n) > 1));
endmodule

// File: tb/hbus_quad_front_tb.sv
module hbus_quad_front_tb_top;
    logic       clk = 1'b0;
    logic       style_strobe, rst_pin, rd_n, wr_n, rw_n;
    logic [3:0] sel_n, chan_irq, int_out, reg_rd_en, reg_wr_en;
    logic [4:0] addr;
    logic [7:0] data_in, data_out, reg_wdata;
    logic [2:0] reg_off;
    logic       data_oe, multi_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    hbus_quad_front dut_i (
        .clk(clk), .style_strobe(style_strobe), .rst_pin(rst_pin),
        .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n), .rw_n(rw_n),
        .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .chan_irq(chan_irq), .int_out(int_out), .reg_rd_en(reg_rd_en),
        .reg_wr_en(reg_wr_en), .reg_off(reg_off), .reg_wdata(reg_wdata),
        .multi_sel(multi_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        sel_n = 4'hF; rd_n = 1'b1; wr_n = 1'b1; rw_n = 1'b1; addr = '0; data_in = '0;
    endtask

    task automatic do_reset(input logic strobe_style);
        @(negedge clk);
        idle();
        style_strobe = strobe_style;
        rst_pin = strobe_style;
        repeat (3) @(negedge clk);
        rst_pin = ~strobe_style;
        @(negedge clk);
    endtask

    task automatic s_write(input int ch, input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        sel_n = ~(4'b1 << ch); addr = {2'b00, off}; data_in = d; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1; sel_n = 4'hF;
        #1;
        chk("R2 write pulse", 32'(reg_wr_en), 32'(4'b1 << ch));
        chk("R2 write offset", 32'(reg_off), 32'(off));
        @(negedge clk);
        chk("R2 pulse one cycle", 32'(reg_wr_en), 0);
    endtask

    task automatic s_read(input logic [3:0] sel, input logic [4:0] a,
                          input logic [7:0] exp_d, input logic [3:0] exp_en, input string req);
        @(negedge clk);
        sel_n = sel; addr = a; rd_n = 1'b0;
        #2;
        chk({req, " read enable"}, 32'(reg_rd_en), 32'(exp_en));
        chk({req, " read data"}, 32'(data_out), 32'(exp_d));
        chk({req, " oe"}, 32'(data_oe), 1);
        chk({req, " offset"}, 32'(reg_off), 32'(a[2:0]));
        @(negedge clk);
        rd_n = 1'b1; sel_n = 4'hF;
    endtask

    task automatic m_write(input int ch, input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        sel_n = 4'b1110; addr = {2'(ch), off}; data_in = d; rw_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R5 no pulse while select low", 32'(reg_wr_en), 0);
        @(negedge clk);
        sel_n = 4'hF;
        #1;
        chk("R5 pulse after select rise", 32'(reg_wr_en), 32'(4'b1 << ch));
        @(negedge clk);
        rw_n = 1'b1;
    endtask

    task automatic m_read(input int ch, input logic [2:0] off, input logic [7:0] exp_d, input string req);
        @(negedge clk);
        sel_n = 4'b1110; rw_n = 1'b1; addr = {2'(ch), off};
        #2;
        chk({req, " read enable"}, 32'(reg_rd_en), 32'(4'b1 << ch));
        chk({req, " read data"}, 32'(data_out), 32'(exp_d));
        @(negedge clk);
        sel_n = 4'hF;
    endtask

    task automatic t_reset_strobe();
        do_reset(1'b1);
        #2;
        chk("R6 idle oe low", 32'(data_oe), 0);
        chk("R6 idle data zero", 32'(data_out), 0);
        s_read(4'b1011, 5'd5, 8'h00, 4'b0100, "R9 cleared after reset");
    endtask

    task automatic t_strobe_rw();
        for (int c = 0; c < 4; c++) s_write(c, 3'd3, 8'h10 + 8'(c));
        s_write(1, 3'd7, 8'hA5);
        for (int c = 0; c < 4; c++)
            s_read(~(4'b1 << c), 5'd3, 8'h10 + 8'(c), 4'b1 << c, "R1");
        s_read(4'b1101, 5'd7, 8'hA5, 4'b0010, "R1 offset 7");
    endtask

    task automatic t_multi();
        @(negedge clk);
        sel_n = 4'b1001; addr = 5'd3; rd_n = 1'b0;
        #2;
        chk("R3 lowest wins", 32'(reg_rd_en), 32'(4'b0010));
        chk("R3 data of lowest", 32'(data_out), 32'h11);
        chk("R3 flag", 32'(multi_sel), 1);
        @(negedge clk);
        rd_n = 1'b1; sel_n = 4'hF;
        #2;
        chk("R3 flag clears", 32'(multi_sel), 0);
    endtask

    task automatic t_strobe_ignore();
        @(negedge clk);
        sel_n = 4'b0111; addr = 5'b11_011; rw_n = 1'b0; rd_n = 1'b0;
        #2;
        chk("R10 upper addr ignored", 32'(reg_rd_en), 32'(4'b1000));
        chk("R10 data", 32'(data_out), 32'h13);
        @(negedge clk);
        idle();
        #2;
        chk("R6 oe drops", 32'(data_oe), 0);
    endtask

    task automatic t_strobe_irq();
        chan_irq = 4'b0101;
        #1 chk("R7 irq pass", 32'(int_out), 32'(4'b0101));
        chan_irq = 4'b1010;
        #1 chk("R7 irq pass 2", 32'(int_out), 32'(4'b1010));
        chan_irq = 4'b0000;
    endtask

    task automatic t_seldir();
        do_reset(1'b0);
        m_read(3, 3'd3, 8'h00, "R9 active-low reset cleared");
        for (int c = 0; c < 4; c++) m_write(c, 3'd2, 8'hC0 + 8'(c));
        for (int c = 0; c < 4; c++) m_read(c, 3'd2, 8'hC0 + 8'(c), "R4");
        m_read(2, 3'd2, 8'hC2, "R9 high pin is not reset");
    endtask

    task automatic t_seldir_ignore();
        @(negedge clk);
        sel_n = 4'b0001; rd_n = 1'b0; wr_n = 1'b0; rw_n = 1'b1; addr = 5'b01_010;
        #2;
        chk("R10 other selects ignored", 32'(data_oe), 0);
        chk("R10 no enable", 32'(reg_rd_en), 0);
        @(negedge clk);
        idle();
        repeat (2) @(negedge clk);
        m_read(1, 3'd2, 8'hC1, "R10 data untouched");
    endtask

    task automatic t_seldir_irq();
        chan_irq = 4'b0000;
        #1 chk("R8 no request", 32'(int_out), 32'(4'b0001));
        chan_irq = 4'b0100;
        #1 chk("R8 request", 32'(int_out), 32'(4'b0000));
        chan_irq = 4'b1111;
        #1 chk("R8 all request", 32'(int_out), 32'(4'b0000));
        chan_irq = 4'b0000;
    endtask

    initial begin
        idle();
        chan_irq = '0;
        style_strobe = 1'b1;
        rst_pin = 1'b1;
        t_reset_strobe();
        t_strobe_rw();
        t_multi();
        t_strobe_ignore();
        t_strobe_irq();
        t_seldir();
        t_seldir_ignore();
        t_seldir_irq();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule